// File: doc/BRIEF.md
# Handshaked Character Serialiser

This block links a small parallel character source, such as a tape or keyboard reader, to a CPU that moves data one bit per clock. The device presents a character and raises its ready line. The microcode polls a synchronised copy of that line and loops until it is high. It then issues the input control code with the memory-write bit low. That captures the character into a shift register and pulses an acknowledge back to the device. Next it repeats the same control code with the memory-write bit high. Each such cycle shifts one bit out on the serial line, which feeds the X-operand selector of the ALU, while the word is written to memory.

Bits leave least significant first. After the character bits are gone the register has drained to zero, so the upper bits of the destination word are written as zeros. The character therefore lands in the low bits of the word. Any other control code leaves the register untouched.

Top module: `serin_port`

## Requirements
- R1: While `rst` is high at a clock edge, the register, `ser_out`, `dev_ack` and `ready_sync` all go to 0 after that edge.
- R2: `ready_sync` equals the value `dev_ready` had SYNC_STAGES (default 2) clock edges earlier.
- R3: When `ctrl_code` equals SEL_CODE (default 4'b0011) and `mem_wr` is 0 at an edge, the register takes `dev_data`, and `ser_out` shows `dev_data[0]` in the next cycle.
- R4: `dev_ack` is high, with no register in its path, exactly in the cycles where `ctrl_code` equals SEL_CODE and `mem_wr` is 0. This gives a one-cycle pulse for a one-cycle load.
- R5: When `ctrl_code` equals SEL_CODE and `mem_wr` is 1, each edge shifts the register right by one. After a load, `ser_out` presents bits 0, 1, 2, 3, 4 of the character on successive shift cycles.
- R6: Once CHAR_W shifts have followed a load, `ser_out` stays 0 for every further shift, so the rest of the word fills with zeros.
- R7: Any `ctrl_code` other than SEL_CODE leaves the register unchanged and keeps `dev_ack` low, whatever the value of `mem_wr`.
- R8: A load in the middle of a shift-out replaces the remaining bits with the new character.
- R9: A device that raises ready with a character and drops it on acknowledge completes a whole transfer: poll, load, then 18 shifted bits that match the character followed by zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Run clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_data | input | CHAR_W | Character from the device |
| dev_ready | input | 1 | Device has a character present (asynchronous) |
| ctrl_code | input | CODE_W | Microcode miscellaneous control field |
| mem_wr | input | 1 | Microcode memory-write bit (0 = load, 1 = shift) |
| ser_out | output | 1 | Serial bit toward the ALU X selector |
| dev_ack | output | 1 | Acknowledge pulse to the device |
| ready_sync | output | 1 | Synchronised ready, used as a branch condition |

## Verification
The bench builds the block with its defaults: CHAR_W of 5, a two-stage synchroniser, and a 4-bit control field with 4'b0011 as the input code. It models an 18-bit word, which leaves 13 bit times after the character. That makes the zero fill well past the drained register observable, along with the two-edge ready latency. The bench also covers a reload part way through a shift-out, and uses character values whose bit patterns show an LSB-first versus MSB-first swap.

// File: rtl/serin_pkg.sv
package serin_pkg;
    localparam int DEF_CHAR_W = 5;
    localparam int DEF_CODE_W = 4;
    localparam int DEF_SYNC   = 2;
    localparam logic [DEF_CODE_W-1:0] DEF_SEL_CODE = 4'b0011;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } sr_op_e;
endpackage

// File: rtl/serin_sync.sv
module serin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= stage_q[i-1];
                end
                // R2
                stage_follow_chk: assert property (@(posedge clk) disable iff (rst)
                    !$past(rst) |-> stage_q[i] == $past(stage_q[i-1]));
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/serin_decode.sv
module serin_decode
    import serin_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter logic [CODE_W-1:0] SEL_CODE = DEF_SEL_CODE
) (
    input  logic [CODE_W-1:0] ctrl_code,
    input  logic              mem_wr,
    output sr_op_e            op,
    output logic              ack
);
    logic hit;
    assign hit = (ctrl_code == SEL_CODE);

    always_comb begin
        op = OP_HOLD;
        if (hit) op = mem_wr ? OP_SHIFT : OP_LOAD;
    end

    assign ack = (op == OP_LOAD);
endmodule

// File: rtl/serin_shreg.sv
module serin_shreg
    import serin_pkg::*;
#(
    parameter int W = DEF_CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  sr_op_e       op,
    input  logic [W-1:0] par_in,
    output logic         ser_bit
);
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            case (op)
                OP_LOAD:  data_q <= par_in;
                OP_SHIFT: data_q <= {1'b0, data_q[W-1:1]};
                default:  data_q <= data_q;
            endcase
        end
    end

    assign ser_bit = data_q[0];

    // R3
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD |=> data_q == $past(par_in));
    // R5
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_SHIFT |=> data_q == ($past(data_q) >> 1));
    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_HOLD |=> $stable(data_q));
endmodule

// File: rtl/serin_port.sv
module serin_port
    import serin_pkg::*;
#(
    parameter int CHAR_W      = DEF_CHAR_W,
    parameter int CODE_W      = DEF_CODE_W,
    parameter int SYNC_STAGES = DEF_SYNC,
    parameter logic [CODE_W-1:0] SEL_CODE = DEF_SEL_CODE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAR_W-1:0] dev_data,
    input  logic              dev_ready,
    input  logic [CODE_W-1:0] ctrl_code,
    input  logic              mem_wr,
    output logic              ser_out,
    output logic              dev_ack,
    output logic              ready_sync
);
    localparam int CNT_W = $clog2(CHAR_W + 1) + 1;

    sr_op_e op;

    serin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(dev_ready), .sync_out(ready_sync)
    );

    serin_decode #(.CODE_W(CODE_W), .SEL_CODE(SEL_CODE)) u_dec (
        .ctrl_code(ctrl_code), .mem_wr(mem_wr), .op(op), .ack(dev_ack)
    );

    serin_shreg #(.W(CHAR_W)) u_sr (
        .clk(clk), .rst(rst), .op(op), .par_in(dev_data), .ser_bit(ser_out)
    );

    // Checker counter: shifts seen since the last load, saturating at CHAR_W.
    logic [CNT_W-1:0] shifts_q;
    always_ff @(posedge clk) begin
        if (rst)                       shifts_q <= CNT_W'(CHAR_W);
        else if (dev_ack)              shifts_q <= '0;
        else if (ctrl_code == SEL_CODE && mem_wr && shifts_q < CNT_W'(CHAR_W))
                                       shifts_q <= shifts_q + 1'b1;
    end

    // R4
    ack_load_chk: assert property (@(posedge clk) disable iff (rst)
        dev_ack |=> ser_out == $past(dev_data[0]));
    // R6
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && shifts_q == CNT_W'(CHAR_W)) |-> !ser_out);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!ser_out && !ready_sync));
endmodule

// File: tb/tb_serin_port.sv
module tb_serin_port;
    localparam int CLK_P  = 10;
    localparam int WORD_W = 18;
    localparam logic [3:0] CODE_IN  = 4'b0011;
    localparam logic [3:0] CODE_NOP = 4'b0000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] dev_data = '0;
    logic       dev_ready = 1'b0;
    logic [3:0] ctrl_code = CODE_NOP;
    logic       mem_wr = 1'b0;
    logic       ser_out, dev_ack, ready_sync;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    serin_port dut (
        .clk(clk), .rst(rst), .dev_data(dev_data), .dev_ready(dev_ready),
        .ctrl_code(ctrl_code), .mem_wr(mem_wr),
        .ser_out(ser_out), .dev_ack(dev_ack), .ready_sync(ready_sync)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance one edge; inputs change and outputs are sampled at negedge + 1.
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic set_op(input logic [3:0] c, input logic w);
        ctrl_code = c;
        mem_wr    = w;
        #1;
    endtask

    task automatic load_char(input logic [4:0] v);
        dev_data = v;
        set_op(CODE_IN, 1'b0);
        check(dev_ack === 1'b1, "R4 ack during load", int'(dev_ack), 1);
        tick();
        set_op(CODE_NOP, 1'b0);
        check(dev_ack === 1'b0, "R4 ack after load", int'(dev_ack), 0);
        check(ser_out === v[0], "R3 bit0 after load", int'(ser_out), int'(v[0]));
    endtask

    task automatic shift_word(input logic [4:0] v, input int first, input string tag);
        set_op(CODE_IN, 1'b1);
        check(dev_ack === 1'b0, "R4 no ack while shifting", int'(dev_ack), 0);
        for (int i = first; i < WORD_W; i++) begin
            logic e;
            e = (i < 5) ? v[i] : 1'b0;
            check(ser_out === e, tag, int'(ser_out), int'(e));
            tick();
        end
        set_op(CODE_NOP, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        check(ser_out === 1'b0,    "R1 ser_out reset",    int'(ser_out), 0);
        check(dev_ack === 1'b0,    "R1 ack reset",        int'(dev_ack), 0);
        check(ready_sync === 1'b0, "R1 ready_sync reset", int'(ready_sync), 0);
        rst = 1'b0;
        tick();
    endtask

    task automatic t_sync();
        dev_ready = 1'b1;
        tick();
        check(ready_sync === 1'b0, "R2 ready after 1 edge", int'(ready_sync), 0);
        tick();
        check(ready_sync === 1'b1, "R2 ready after 2 edges", int'(ready_sync), 1);
        dev_ready = 1'b0;
        tick();
        check(ready_sync === 1'b1, "R2 fall after 1 edge", int'(ready_sync), 1);
        tick();
        check(ready_sync === 1'b0, "R2 fall after 2 edges", int'(ready_sync), 0);
    endtask

    task automatic t_load_shift(input logic [4:0] v);
        load_char(v);
        shift_word(v, 0, "R5 R6 serial bit");
    endtask

    task automatic t_ignore();
        load_char(5'b10110);
        for (int c = 0; c < 16; c++) begin
            if (c == int'(CODE_IN)) continue;
            dev_data = 5'b01001;
            set_op(4'(c), c[0]);
            check(dev_ack === 1'b0, "R7 no ack on other code", int'(dev_ack), 0);
            tick();
        end
        set_op(CODE_NOP, 1'b0);
        shift_word(5'b10110, 0, "R7 register kept");
    endtask

    task automatic t_reload();
        load_char(5'b11111);
        set_op(CODE_IN, 1'b1);
        tick(); tick();
        load_char(5'b00101);
        shift_word(5'b00101, 0, "R8 reload mid shift");
    endtask

    task automatic t_handshake(input logic [4:0] v);
        int wait_n = 0;
        dev_data  = v;
        dev_ready = 1'b1;
        set_op(CODE_NOP, 1'b0);
        while (ready_sync !== 1'b1 && wait_n < 10) begin
            tick();
            wait_n++;
        end
        check(ready_sync === 1'b1, "R9 ready seen", int'(ready_sync), 1);
        set_op(CODE_IN, 1'b0);
        check(dev_ack === 1'b1, "R9 ack issued", int'(dev_ack), 1);
        tick();
        dev_ready = 1'b0;
        dev_data  = ~v;
        shift_word(v, 0, "R9 handshake stream");
        tick(); tick();
        check(ready_sync === 1'b0, "R9 ready dropped", int'(ready_sync), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_sync();
        t_load_shift(5'b00001);
        t_load_shift(5'b10000);
        t_load_shift(5'b11010);
        t_ignore();
        t_reload();
        t_handshake(5'b01101);
        t_handshake(5'b10011);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule